// File: doc/BRIEF.md
# Four-Path Semi-Global Cost Aggregator

This block takes a stream of per-pixel matching-cost vectors, one vector of D disparity costs per pixel in raster order, and aggregates them along four causal paths: from the left neighbour, from the upper-left, from directly above and from the upper-right. Each path applies the usual semi-global smoothness penalties. The four path costs are summed for every disparity, and a winner-take-all stage picks the disparity with the lowest aggregate. Every path uses only pixels that have already been scanned. The whole frame is therefore processed in one top-to-bottom pass. The only storage is one row of path costs per upper path, plus a register for the left path.

The input cost is typically a Hamming distance between census codes, summed over a 3x3 window. The block accepts one pixel per clock, and the stream may pause at any time. A start-of-frame flag on the first pixel fixes the position in the image. The output gives the winning disparity, its aggregated cost and the aggregated costs of the two adjacent disparities, so that a later stage can do sub-pixel refinement.

Top module: `sgm4_aggregator`

## Requirements
- R1: After reset `out_valid` is 0 and stays 0 until a pixel is accepted.
- R2: Each accepted pixel (`in_valid`=1 at a rising edge) produces exactly one result with `out_valid`=1 in the following cycle. A cycle with `in_valid`=0 produces `out_valid`=0 in the following cycle.
- R3: For each path r and disparity d, the path cost is L = C(d) + min over k of (Lprev(k) + pen(|k-d|)) - min over k of Lprev(k). Here pen is 0 for equal disparity, P1 for a difference of 1 and P2 for any larger difference. Lprev is that path's cost vector at the predecessor pixel: the pixel at (x-1,y) for the left path, (x-1,y-1) for the upper-left path, (x,y-1) for the upper path and (x+1,y-1) for the upper-right path.
- R4: Every path cost saturates at 2^PW-1 (2047 with PW=11) and never wraps.
- R5: A path whose predecessor lies outside the image (x=0 for the left and upper-left paths, x=WIDTH-1 for the upper-right path, row 0 for the three upper paths) contributes 0, so its path cost equals the input cost. The first pixel of a frame therefore aggregates to 4*C(d).
- R6: The aggregate cost of disparity d is the sum of the four path costs. `out_cost_min` is the smallest aggregate, and `out_disp` is its disparity index.
- R7: When several disparities share the smallest aggregate, the lowest index wins.
- R8: `out_cost_lo` is the aggregate at `out_disp`-1 and `out_cost_hi` is the aggregate at `out_disp`+1. Either one reads all ones (8191 for PW=11) when that neighbour is outside 0..D-1.
- R9: A pixel with `in_sof`=1 is position (0,0) and restarts the frame regardless of earlier input. Pixels then advance in x, and after WIDTH pixels the row ends and x returns to 0.
- R10: Idle cycles between pixels change neither the position nor any stored cost, so a stream with gaps gives the same results as the same stream sent without gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | A pixel's cost vector is present this cycle |
| in_sof | input | 1 | Marks the first pixel of a frame (qualified by in_valid) |
| in_cost | input | D*CIN_W | Matching costs, disparity d in bits [d*CIN_W +: CIN_W] |
| out_valid | output | 1 | Result present |
| out_disp | output | DISP_W | Winning disparity index |
| out_cost_min | output | PW+2 | Aggregated cost at the winning disparity |
| out_cost_lo | output | PW+2 | Aggregated cost at disparity out_disp-1, all ones if none |
| out_cost_hi | output | PW+2 | Aggregated cost at disparity out_disp+1, all ones if none |

## Verification
A reference model in the bench recomputes every path with an explicit penalty search over all disparity pairs. It is compared with the block on several frames. A diagonal ramp moves the winner between pixels and exercises all three penalty levels. A flat cost separates the lowest-index tie rule from any other choice. A cost that falls with d puts the winner on the top edge, which tests the all-ones neighbour. A frame with near-full costs drives the paths into saturation. A pseudo-random frame with idle gaps, and a frame abandoned mid-row and then restarted, test that position and row storage depend only on accepted pixels and on the start-of-frame flag.

// File: rtl/sgm_pkg.sv
package sgm_pkg;

  localparam int NPATH = 4;

  typedef enum logic [1:0] {
    PATH_LEFT  = 2'd0,
    PATH_UPL   = 2'd1,
    PATH_UP    = 2'd2,
    PATH_UPR   = 2'd3
  } path_dir_e;

  // clamp an unsigned value to a ceiling
  function automatic logic [31:0] sat_u(input logic [31:0] v, input logic [31:0] lim);
    return (v > lim) ? lim : v;
  endfunction

  // smaller of two unsigned values
  function automatic logic [31:0] min_u(input logic [31:0] a, input logic [31:0] b);
    return (b < a) ? b : a;
  endfunction

endpackage

// File: rtl/sgm_path_step.sv
module sgm_path_step
  import sgm_pkg::*;
#(
  parameter int D     = 32,
  parameter int CIN_W = 6,
  parameter int PW    = 11,
  parameter int P1    = 8,
  parameter int P2    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chk_en,
  input  logic              prev_ok,
  input  logic [D*CIN_W-1:0] cost_i,
  input  logic [D*PW-1:0]   prev_i,
  output logic [D*PW-1:0]   path_o
);

  localparam logic [31:0] MAXV = 32'((1 << PW) - 1);
  localparam logic [31:0] NONE = 32'hFFFF_FFFF;

  logic [PW-1:0]    prv [D];
  logic [CIN_W-1:0] cst [D];
  logic [PW-1:0]    nxt [D];
  logic [PW-1:0]    prv_min;

  for (genvar g = 0; g < D; g++) begin : g_unpack
    assign prv[g] = prev_i[g*PW +: PW];
    assign cst[g] = cost_i[g*CIN_W +: CIN_W];
    assign path_o[g*PW +: PW] = nxt[g];
  end

  always_comb begin
    prv_min = prv[0];
    for (int k = 1; k < D; k++) begin
      if (prv[k] < prv_min) prv_min = prv[k];
    end
  end

  for (genvar g = 0; g < D; g++) begin : g_disp
    logic [31:0] c_same, c_lo, c_hi, c_far, best, raw, pick;

    assign c_same = 32'(prv[g]);
    if (g > 0) begin : g_lo
      assign c_lo = 32'(prv[g-1]) + 32'(P1);
    end else begin : g_lo_none
      assign c_lo = NONE;
    end
    if (g < D-1) begin : g_hi
      assign c_hi = 32'(prv[g+1]) + 32'(P1);
    end else begin : g_hi_none
      assign c_hi = NONE;
    end
    assign c_far = 32'(prv_min) + 32'(P2);
    assign best  = min_u(min_u(c_same, c_far), min_u(c_lo, c_hi));
    assign raw   = 32'(cst[g]) + best - 32'(prv_min);
    assign pick  = prev_ok ? raw : 32'(cst[g]);
    assign nxt[g] = PW'(sat_u(pick, MAXV));

    // R5: with no predecessor the path carries the raw cost
    a_r5_border_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
      chk_en && !prev_ok && (32'(cst[g]) <= MAXV) |-> 32'(nxt[g]) == 32'(cst[g]));

    // R3: smoothing adds at most the large penalty above the raw cost
    a_r3_rise_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      chk_en && prev_ok |-> 32'(nxt[g]) <= 32'(cst[g]) + 32'(P2));

    // R4: never below the (clamped) raw cost, i.e. no wrap-around
    a_r4_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      chk_en |-> 32'(nxt[g]) >= sat_u(32'(cst[g]), MAXV));
  end

endmodule

// File: rtl/sgm_wta.sv
module sgm_wta #(
  parameter int D      = 32,
  parameter int SW     = 13,
  parameter int DISP_W = 5
) (
  input  logic [D*SW-1:0]   sums_i,
  output logic [DISP_W-1:0] disp_o,
  output logic [SW-1:0]     min_o,
  output logic [SW-1:0]     lo_o,
  output logic [SW-1:0]     hi_o
);

  logic [SW-1:0] s [D];

  for (genvar g = 0; g < D; g++) begin : g_unpack
    assign s[g] = sums_i[g*SW +: SW];
  end

  always_comb begin
    disp_o = '0;
    min_o  = s[0];
    // strict compare keeps the lowest index on ties
    for (int k = 1; k < D; k++) begin
      if (s[k] < min_o) begin
        min_o  = s[k];
        disp_o = DISP_W'(k);
      end
    end
    lo_o = (disp_o == '0) ? '1 : s[disp_o - DISP_W'(1)];
    hi_o = (32'(disp_o) == D-1) ? '1 : s[disp_o + DISP_W'(1)];
  end

endmodule

// File: rtl/sgm4_aggregator.sv
module sgm4_aggregator
  import sgm_pkg::*;
#(
  parameter int D     = 32,
  parameter int WIDTH = 64,
  parameter int CIN_W = 6,
  parameter int PW    = 11,
  parameter int P1    = 8,
  parameter int P2    = 32,
  localparam int DISP_W = (D > 1) ? $clog2(D) : 1,
  localparam int SW     = PW + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic               in_sof,
  input  logic [D*CIN_W-1:0] in_cost,
  output logic               out_valid,
  output logic [DISP_W-1:0]  out_disp,
  output logic [SW-1:0]      out_cost_min,
  output logic [SW-1:0]      out_cost_lo,
  output logic [SW-1:0]      out_cost_hi
);

  localparam int X_W   = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam int VEC_W = D * PW;
  localparam logic [X_W-1:0] X_LAST = X_W'(WIDTH - 1);

  // ---------------- position tracking ----------------
  logic [X_W-1:0] x_cnt;
  logic           top_row;
  logic [X_W-1:0] cur_x;
  logic           cur_top;
  logic           at_left, at_right;

  assign cur_x    = in_sof ? '0 : x_cnt;
  assign cur_top  = in_sof ? 1'b1 : top_row;
  assign at_left  = (cur_x == '0);
  assign at_right = (cur_x == X_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_cnt   <= '0;
      top_row <= 1'b1;
    end else if (in_valid) begin
      if (at_right) begin
        x_cnt   <= '0;
        top_row <= 1'b0;
      end else begin
        x_cnt   <= cur_x + X_W'(1);
        top_row <= cur_top;
      end
    end
  end

  // ---------------- path storage ----------------
  logic [VEC_W-1:0] mem_ul [WIDTH];
  logic [VEC_W-1:0] mem_up [WIDTH];
  logic [VEC_W-1:0] mem_ur [WIDTH];
  logic [VEC_W-1:0] left_vec;
  logic             ul_pend_v;
  logic [X_W-1:0]   ul_pend_x;
  logic [VEC_W-1:0] ul_pend_vec;

  logic [X_W-1:0] ul_idx, ur_idx;
  assign ul_idx = at_left  ? '0    : cur_x - X_W'(1);
  assign ur_idx = at_right ? cur_x : cur_x + X_W'(1);

  logic [VEC_W-1:0] prev_vec [NPATH];
  logic             prev_ok  [NPATH];
  logic [VEC_W-1:0] path_vec [NPATH];

  assign prev_vec[PATH_LEFT] = left_vec;
  assign prev_vec[PATH_UPL]  = mem_ul[ul_idx];
  assign prev_vec[PATH_UP]   = mem_up[cur_x];
  assign prev_vec[PATH_UPR]  = mem_ur[ur_idx];

  assign prev_ok[PATH_LEFT] = !at_left;
  assign prev_ok[PATH_UPL]  = !cur_top && !at_left;
  assign prev_ok[PATH_UP]   = !cur_top;
  assign prev_ok[PATH_UPR]  = !cur_top && !at_right;

  for (genvar p = 0; p < NPATH; p++) begin : g_path
    sgm_path_step #(
      .D(D), .CIN_W(CIN_W), .PW(PW), .P1(P1), .P2(P2)
    ) u_step (
      .clk     (clk),
      .rst_n   (rst_n),
      .chk_en  (in_valid),
      .prev_ok (prev_ok[p]),
      .cost_i  (in_cost),
      .prev_i  (prev_vec[p]),
      .path_o  (path_vec[p])
    );
  end

  // the upper-left row write is held back one pixel so the next pixel
  // still reads the previous row's entry at this column
  always_ff @(posedge clk) begin
    if (in_valid) begin
      mem_up[cur_x] <= path_vec[PATH_UP];
      mem_ur[cur_x] <= path_vec[PATH_UPR];
      left_vec      <= path_vec[PATH_LEFT];
      if (ul_pend_v) mem_ul[ul_pend_x] <= ul_pend_vec;
      ul_pend_x     <= cur_x;
      ul_pend_vec   <= path_vec[PATH_UPL];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ul_pend_v <= 1'b0;
    else if (in_valid) ul_pend_v <= 1'b1;
  end

  // ---------------- aggregation and selection ----------------
  logic [D*SW-1:0] sums;
  for (genvar g = 0; g < D; g++) begin : g_sum
    assign sums[g*SW +: SW] = SW'(path_vec[PATH_LEFT][g*PW +: PW])
                            + SW'(path_vec[PATH_UPL][g*PW +: PW])
                            + SW'(path_vec[PATH_UP][g*PW +: PW])
                            + SW'(path_vec[PATH_UPR][g*PW +: PW]);
  end

  logic [DISP_W-1:0] win_disp;
  logic [SW-1:0]     win_min, win_lo, win_hi;

  sgm_wta #(.D(D), .SW(SW), .DISP_W(DISP_W)) u_wta (
    .sums_i (sums),
    .disp_o (win_disp),
    .min_o  (win_min),
    .lo_o   (win_lo),
    .hi_o   (win_hi)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_disp     <= '0;
      out_cost_min <= '0;
      out_cost_lo  <= '0;
      out_cost_hi  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_disp     <= win_disp;
        out_cost_min <= win_min;
        out_cost_lo  <= win_lo;
        out_cost_hi  <= win_hi;
      end
    end
  end

  // ---------------- assertions ----------------
  // R2: one result per accepted pixel, one cycle later
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R10: idle cycles keep the scan position
  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(x_cnt) && $stable(top_row));

  // R9: the row wraps after the last column
  a_r9_row_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && at_right |=> (x_cnt == '0) && !top_row);

  // R6: the reported minimum is not above either neighbour
  a_r6_min_bounds: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_cost_min <= out_cost_lo) && (out_cost_min <= out_cost_hi));

  // R7: a lower index never ties the winner
  a_r7_strict_left: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (out_disp != '0) |-> out_cost_lo > out_cost_min);

  // R8: the missing lower neighbour reads all ones
  a_r8_low_edge: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (out_disp == '0) |-> out_cost_lo == '1);

endmodule

// File: tb/sgm4_aggregator_test.sv
`timescale 1ns/1ps
module sgm4_aggregator_test;

  localparam int D     = 8;
  localparam int W     = 5;
  localparam int H     = 4;
  localparam int CIN_W = 11;
  localparam int PW    = 11;
  localparam int P1    = 3;
  localparam int P2    = 10;
  localparam int DW    = 3;
  localparam int SW    = PW + 2;
  localparam int SAT   = 2047;
  localparam int NONE  = 8191;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               in_valid = 1'b0;
  logic               in_sof = 1'b0;
  logic [D*CIN_W-1:0] in_cost = '0;
  logic               out_valid;
  logic [DW-1:0]      out_disp;
  logic [SW-1:0]      out_cost_min, out_cost_lo, out_cost_hi;

  always #10 clk = ~clk;  // 50 MHz

  sgm4_aggregator #(
    .D(D), .WIDTH(W), .CIN_W(CIN_W), .PW(PW), .P1(P1), .P2(P2)
  ) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .in_cost(in_cost), .out_valid(out_valid), .out_disp(out_disp),
    .out_cost_min(out_cost_min), .out_cost_lo(out_cost_lo), .out_cost_hi(out_cost_hi)
  );

  int n_tests = 0;
  int n_fail  = 0;

  int refL [4][H][W][D];
  int exp_disp, exp_min, exp_lo, exp_hi;
  bit pend = 0;

  function automatic int iabs(input int v);
    return (v < 0) ? -v : v;
  endfunction

  function automatic int gen(input int pat, input int x, input int y, input int d);
    case (pat)
      0: return 4 * iabs(d - ((x + 2*y) % D)) + ((x + y) % 3);
      1: return 20;
      2: return (D - 1 - d) * 7 + x;
      3: return (d == 0) ? 0 : 2040 + ((x + y) % 8);
      4: return ((x*37 + y*11 + d*13) ^ (x*d)) % 50;
      default: return 30 + 5 * iabs(d - 3);
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int expv, input string what);
    n_tests++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  // independent model: explicit search over all predecessor disparities
  task automatic ref_pixel(input int pat, input int x, input int y);
    int dxs[4] = '{-1, -1, 0, 1};
    int dys[4] = '{0, -1, -1, -1};
    int sum[D];
    for (int d = 0; d < D; d++) sum[d] = 0;
    for (int p = 0; p < 4; p++) begin
      int px = x + dxs[p];
      int py = y + dys[p];
      bit has = (px >= 0) && (px < W) && (py >= 0);
      int pm = 1 << 30;
      if (has) for (int k = 0; k < D; k++) if (refL[p][py][px][k] < pm) pm = refL[p][py][px][k];
      for (int d = 0; d < D; d++) begin
        int c = gen(pat, x, y, d);
        int v;
        if (!has) v = c;
        else begin
          int best = 1 << 30;
          for (int k = 0; k < D; k++) begin
            int pen = (k == d) ? 0 : ((iabs(k - d) == 1) ? P1 : P2);
            if (refL[p][py][px][k] + pen < best) best = refL[p][py][px][k] + pen;
          end
          v = c + best - pm;
        end
        if (v > SAT) v = SAT;
        refL[p][y][x][d] = v;
        sum[d] += v;
      end
    end
    exp_disp = 0;
    for (int d = 1; d < D; d++) if (sum[d] < sum[exp_disp]) exp_disp = d;
    exp_min = sum[exp_disp];
    exp_lo  = (exp_disp == 0) ? NONE : sum[exp_disp - 1];
    exp_hi  = (exp_disp == D-1) ? NONE : sum[exp_disp + 1];
  endtask

  task automatic check_out(input string tag);
    check(tag, int'(out_valid), 1, "out_valid");
    check(tag, int'(out_disp), exp_disp, "disp");
    check(tag, int'(out_cost_min), exp_min, "cost_min");
    check(tag, int'(out_cost_lo), exp_lo, "cost_lo");
    check(tag, int'(out_cost_hi), exp_hi, "cost_hi");
  endtask

  task automatic drive_px(input int pat, input int x, input int y, input string tag);
    @(negedge clk);
    if (pend) check_out(tag);
    in_valid = 1'b1;
    in_sof   = (x == 0 && y == 0);
    for (int d = 0; d < D; d++) in_cost[d*CIN_W +: CIN_W] = CIN_W'(gen(pat, x, y, d));
    ref_pixel(pat, x, y);
    pend = 1;
  endtask

  task automatic idle_cycle(input string tag);
    @(negedge clk);
    if (pend) check_out(tag);
    else check(tag, int'(out_valid), 0, "idle out_valid");
    in_valid = 1'b0;
    in_sof   = 1'b0;
    pend = 0;
  endtask

  task automatic run_frame(input int pat, input int rows, input int npix, input bit gaps, input string tag);
    int cnt = 0;
    for (int y = 0; y < rows; y++) begin
      for (int x = 0; x < W; x++) begin
        if (cnt < npix) begin
          drive_px(pat, x, y, tag);
          if (gaps && ((x + y) % 2 == 0)) begin
            idle_cycle(tag);
            idle_cycle(tag);
          end
          cnt++;
        end
      end
    end
    idle_cycle(tag);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1", int'(out_valid), 0, "out_valid after reset");
    idle_cycle("R1");
  endtask

  task automatic t_border;
    drive_px(5, 0, 0, "R5");
    idle_cycle("R5");
    check("R5", int'(out_disp), 3, "first pixel disp");
    check("R5", int'(out_cost_min), 120, "first pixel 4*C");
    check("R5", int'(out_cost_lo), 140, "first pixel lo");
    check("R5", int'(out_cost_hi), 140, "first pixel hi");
  endtask

  task automatic t_ramp;    run_frame(0, H, W*H, 0, "R3_R6"); endtask
  task automatic t_ties;    run_frame(1, H, W*H, 0, "R7");    endtask
  task automatic t_sat;     run_frame(3, H, W*H, 0, "R4");    endtask
  task automatic t_gaps;    run_frame(4, H, W*H, 1, "R10_R2"); endtask

  task automatic t_edge;
    drive_px(2, 0, 0, "R8");
    idle_cycle("R8");
    check("R8", int'(out_disp), D-1, "top edge disp");
    check("R8", int'(out_cost_hi), NONE, "missing upper neighbour");
    run_frame(2, H, W*H, 0, "R8");
  endtask

  task automatic t_restart;
    run_frame(4, 2, 7, 0, "R9");
    run_frame(0, H, W*H, 0, "R9");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #3 rst_n = 1'b1;
    t_reset();
    t_border();
    t_ramp();
    t_ties();
    t_edge();
    t_sat();
    t_gaps();
    t_restart();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule